// File: doc/BRIEF.md
# Banked Multi-Mode Programmable FIR

This block filters an I/Q sample pair at full rate with a programmable FIR built from one shared array of 32 coefficient slots. A per-stream mode field decides how the slots are used: the I and Q streams can each run one 32-tap real filter, or the slot array can be split so that I and Q each get their own 16-tap or 8-tap real filter. Mode codes without a filter here (bypass and the unsupported topologies) pass samples through unchanged.

Coefficients are written into four offline banks while the filter keeps running. A bank-mask write can update one bank or several at once. A transfer strobe copies a whole offline bank into the active set in a single clock edge. A routing register field, or two GPIO pins, picks which bank the strobe copies. After the FIR sum, each stream applies a coarse left-shift gain in 6 dB steps, then a fine multiply by (code+1)/64, and then saturates to 16 bits.

Top module: `banked_pfir`

## Requirements
- R1: After reset, res_valid, res_i and res_q are 0. Both mode fields reset to code 0 (bypass), the shift codes reset to 0 and the fine codes reset to 63. The bank select resets to register mode, bank 0. All coefficients reset to 0.
- R2: A sample accepted on a clock edge with smp_valid=1 gives res_valid=1 for exactly one cycle, after the second rising edge that follows. res_i and res_q hold their values between results.
- R3: Mode code 7 filters the stream with all 32 active slots: y = (sum over k of c[k]*x[n-k]) >>> 15, with slot 0 applied to the newest sample.
- R4: Mode code 2 gives the I stream slots 0..15 and the Q stream slots 16..31, each as a 16-tap filter.
- R5: Mode code 1 gives the I stream slots 0..7 and the Q stream slots 16..23, each as an 8-tap filter.
- R6: Mode codes 0, 3, 4, 5 and 6 pass the newest input sample to the output unchanged, with no gain applied.
- R7: coef_wr writes coef_data to slot coef_addr of every offline bank whose bit is set in coef_bank_mask (bit n = bank n, 0xF = all four). Offline writes do not change the output until a transfer.
- R8: coef_xfer copies all 32 slots of one offline bank into the active set on one edge. The bank is route_bank_reg when route_sel_gpio=0, and bank_gpio[1:0] when route_sel_gpio=1. Each output uses coefficients from a single set.
- R9: Shift codes 0..4 shift the filtered value left by 0..4 bits (0 to 24 dB). Codes 5..7 act as code 0.
- R10: The fine code f multiplies the shifted value by (f+1) and then shifts right arithmetically by 6. Code 63 is unity.
- R11: The scaled result saturates to the range -32768..32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_i | input | 16 | I input sample, signed |
| smp_q | input | 16 | Q input sample, signed |
| coef_wr | input | 1 | Offline coefficient write strobe |
| coef_bank_mask | input | 4 | Banks written by coef_wr |
| coef_addr | input | 5 | Slot index for coef_wr |
| coef_data | input | 16 | Q1.15 coefficient |
| coef_xfer | input | 1 | Copy the selected offline bank to the active set |
| route_we | input | 1 | Load the mode and bank-select fields |
| route_mode_i | input | 3 | I stream mode code |
| route_mode_q | input | 3 | Q stream mode code |
| route_sel_gpio | input | 1 | 1 = bank_gpio picks the bank, 0 = route_bank_reg picks it |
| route_bank_reg | input | 2 | Bank index in register mode |
| gain_we | input | 1 | Load the gain fields |
| gain_shift_i | input | 3 | I shift code |
| gain_shift_q | input | 3 | Q shift code |
| gain_fine_i | input | 6 | I fine scalar code |
| gain_fine_q | input | 6 | Q fine scalar code |
| bank_gpio | input | 2 | Bank index in GPIO mode |
| res_valid | output | 1 | Result strobe |
| res_i | output | 16 | I result, signed |
| res_q | output | 16 | Q result, signed |

## Verification
The bench builds the block with its default parameters: 32 slots, four banks, and 16-bit samples and coefficients. With these values, every split of the slot array can be reached, including the Q half starting at slot 16, as can every bank index from the register field and from the pins, and a 0xF mask write. A 4-bit shift combined with full-scale coefficients drives the result into both saturation limits. A reference model in the bench tracks the sample history and the offline and active coefficient sets, so each result is compared against a value computed from the requirements.

// File: rtl/pfir_pkg.sv
package pfir_pkg;

    localparam int unsigned MODE_W  = 3;
    localparam int unsigned SHIFT_W = 3;
    localparam int unsigned FINE_W  = 6;
    localparam int unsigned MAX_SHIFT = 4;

    localparam logic [MODE_W-1:0] MODE_REAL_QTR  = 3'd1;
    localparam logic [MODE_W-1:0] MODE_REAL_HALF = 3'd2;
    localparam logic [MODE_W-1:0] MODE_REAL_FULL = 3'd7;

    typedef struct packed {
        logic [MODE_W-1:0] mode_i;
        logic [MODE_W-1:0] mode_q;
        logic              sel_gpio;
        logic [1:0]        bank_reg;
    } route_cfg_t;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic [FINE_W-1:0]  fine;
    } gain_cfg_t;

    // number of taps a stream runs in a mode (0 means pass-through)
    function automatic int unsigned slot_count(logic [MODE_W-1:0] m, int unsigned n);
        case (m)
            MODE_REAL_FULL: return n;
            MODE_REAL_HALF: return n / 2;
            MODE_REAL_QTR:  return n / 4;
            default:        return 0;
        endcase
    endfunction

    // first slot used by a stream; split modes move Q into the upper half
    function automatic int unsigned slot_base(logic [MODE_W-1:0] m, bit is_q, int unsigned n);
        if (is_q && (m == MODE_REAL_HALF || m == MODE_REAL_QTR))
            return n / 2;
        return 0;
    endfunction

    function automatic logic [SHIFT_W-1:0] shift_amount(logic [SHIFT_W-1:0] code);
        return (int'(code) <= MAX_SHIFT) ? code : '0;
    endfunction

endpackage

// File: rtl/pfir_coef_store.sv
module pfir_coef_store #(
    parameter int unsigned NTAP  = 32,
    parameter int unsigned CW    = 16,
    parameter int unsigned NBANK = 4,
    parameter int unsigned AW    = $clog2(NTAP),
    parameter int unsigned BW    = $clog2(NBANK)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_en,
    input  logic [NBANK-1:0]           load_mask,
    input  logic [AW-1:0]              load_addr,
    input  logic [CW-1:0]              load_coef,
    input  logic                       xfer,
    input  logic [BW-1:0]              xfer_bank,
    output logic [NTAP-1:0][CW-1:0]    active
);

    logic [NTAP-1:0][CW-1:0] bank_q [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[g] <= '0;
            else if (load_en && load_mask[g])
                bank_q[g][load_addr] <= load_coef;
        end
    end

    // whole-set copy on one edge keeps every output on a single coefficient set
    always_ff @(posedge clk) begin
        if (rst)
            active <= '0;
        else if (xfer)
            active <= bank_q[xfer_bank];
    end

    AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst)
        xfer |=> active == $past(bank_q[xfer_bank])); // R8

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(active)); // R7

endmodule

// File: rtl/pfir_branch.sv
module pfir_branch
    import pfir_pkg::*;
#(
    parameter int unsigned NTAP = 32,
    parameter int unsigned DW   = 16,
    parameter int unsigned CW   = 16,
    parameter bit          IS_Q = 1'b0,
    parameter int unsigned AW   = $clog2(NTAP)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [DW-1:0]            din,
    input  logic [MODE_W-1:0]        mode,
    input  gain_cfg_t                gain,
    input  logic [NTAP-1:0][CW-1:0]  coefs,
    output logic [DW-1:0]            dout,
    output logic                     dout_valid
);

    localparam int unsigned EW = DW + CW + AW + MAX_SHIFT + FINE_W + 4;
    localparam logic signed [EW-1:0] SAT_HI = EW'((2 ** (DW - 1)) - 1);
    localparam logic signed [EW-1:0] SAT_LO = -SAT_HI - EW'(1);

    logic [NTAP-1:0][DW-1:0] line_q;
    logic                    stage_v;

    int unsigned             n_taps;
    int unsigned             first;
    logic                    pass_thru;
    logic [AW-1:0]           idx;
    logic signed [EW-1:0]    acc, filt, shifted, prod, scaled;
    logic [DW-1:0]           sat_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= '0;
            stage_v <= 1'b0;
        end else begin
            stage_v <= in_valid;
            if (in_valid)
                line_q <= {line_q[NTAP-2:0], din};
        end
    end

    assign n_taps    = slot_count(mode, NTAP);
    assign first     = slot_base(mode, IS_Q, NTAP);
    assign pass_thru = (n_taps == 0);

    always_comb begin
        acc = '0;
        idx = '0;
        for (int k = 0; k < NTAP; k++) begin
            if (k < int'(n_taps)) begin
                idx = AW'(first + unsigned'(k));
                acc = acc + EW'($signed(coefs[idx])) * EW'($signed(line_q[k]));
            end
        end
        filt    = acc >>> (CW - 1);
        shifted = filt <<< shift_amount(gain.shift);
        prod    = shifted * EW'($signed({2'b00, gain.fine} + 8'd1));
        scaled  = prod >>> FINE_W;
        if (scaled > SAT_HI)
            sat_val = SAT_HI[DW-1:0];
        else if (scaled < SAT_LO)
            sat_val = SAT_LO[DW-1:0];
        else
            sat_val = scaled[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= stage_v;
            if (stage_v)
                dout <= pass_thru ? line_q[0] : sat_val;
        end
    end

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        (stage_v && pass_thru) |=> dout == $past(line_q[0])); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stage_v |=> $stable(dout)); // R2

endmodule

// File: rtl/banked_pfir.sv
module banked_pfir
    import pfir_pkg::*;
#(
    parameter int unsigned NTAP  = 32,
    parameter int unsigned NBANK = 4,
    parameter int unsigned DW    = 16,
    parameter int unsigned CW    = 16,
    parameter int unsigned AW    = $clog2(NTAP),
    parameter int unsigned BW    = $clog2(NBANK)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [DW-1:0]       smp_i,
    input  logic [DW-1:0]       smp_q,
    input  logic                coef_wr,
    input  logic [NBANK-1:0]    coef_bank_mask,
    input  logic [AW-1:0]       coef_addr,
    input  logic [CW-1:0]       coef_data,
    input  logic                coef_xfer,
    input  logic                route_we,
    input  logic [2:0]          route_mode_i,
    input  logic [2:0]          route_mode_q,
    input  logic                route_sel_gpio,
    input  logic [1:0]          route_bank_reg,
    input  logic                gain_we,
    input  logic [2:0]          gain_shift_i,
    input  logic [2:0]          gain_shift_q,
    input  logic [5:0]          gain_fine_i,
    input  logic [5:0]          gain_fine_q,
    input  logic [1:0]          bank_gpio,
    output logic                res_valid,
    output logic [DW-1:0]       res_i,
    output logic [DW-1:0]       res_q
);

    route_cfg_t              route_q;
    gain_cfg_t               gain_iq [2];
    logic [BW-1:0]           xfer_bank;
    logic [NTAP-1:0][CW-1:0] coefs;

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q    <= '0;
            gain_iq[0] <= '{shift: '0, fine: '1};
            gain_iq[1] <= '{shift: '0, fine: '1};
        end else begin
            if (route_we)
                route_q <= '{mode_i: route_mode_i, mode_q: route_mode_q,
                             sel_gpio: route_sel_gpio, bank_reg: route_bank_reg};
            if (gain_we) begin
                gain_iq[0] <= '{shift: gain_shift_i, fine: gain_fine_i};
                gain_iq[1] <= '{shift: gain_shift_q, fine: gain_fine_q};
            end
        end
    end

    assign xfer_bank = BW'(route_q.sel_gpio ? bank_gpio : route_q.bank_reg);

    pfir_coef_store #(.NTAP(NTAP), .CW(CW), .NBANK(NBANK)) u_store (
        .clk       (clk),
        .rst       (rst),
        .load_en   (coef_wr),
        .load_mask (coef_bank_mask),
        .load_addr (coef_addr),
        .load_coef (coef_data),
        .xfer      (coef_xfer),
        .xfer_bank (xfer_bank),
        .active    (coefs)
    );

    for (genvar b = 0; b < 2; b++) begin : g_br
        logic [DW-1:0]     d_in;
        logic [MODE_W-1:0] m_sel;
        logic [DW-1:0]     d_out;
        logic              d_vld;
        if (b == 0) begin : g_i
            assign d_in  = smp_i;
            assign m_sel = route_q.mode_i;
        end else begin : g_q
            assign d_in  = smp_q;
            assign m_sel = route_q.mode_q;
        end
        pfir_branch #(.NTAP(NTAP), .DW(DW), .CW(CW), .IS_Q(b == 1)) u_branch (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (smp_valid),
            .din        (d_in),
            .mode       (m_sel),
            .gain       (gain_iq[b]),
            .coefs      (coefs),
            .dout       (d_out),
            .dout_valid (d_vld)
        );
    end

    assign res_i     = g_br[0].d_out;
    assign res_q     = g_br[1].d_out;
    assign res_valid = g_br[0].d_vld & g_br[1].d_vld;

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> ##1 res_valid); // R2

    AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ##1 !res_valid); // R2

endmodule

// File: tb/test_banked_pfir.sv
module test_banked_pfir;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_i = '0, smp_q = '0;
    logic        coef_wr = 1'b0;
    logic [3:0]  coef_bank_mask = '0;
    logic [4:0]  coef_addr = '0;
    logic [15:0] coef_data = '0;
    logic        coef_xfer = 1'b0;
    logic        route_we = 1'b0;
    logic [2:0]  route_mode_i = '0, route_mode_q = '0;
    logic        route_sel_gpio = 1'b0;
    logic [1:0]  route_bank_reg = '0;
    logic        gain_we = 1'b0;
    logic [2:0]  gain_shift_i = '0, gain_shift_q = '0;
    logic [5:0]  gain_fine_i = '0, gain_fine_q = '0;
    logic [1:0]  bank_gpio = '0;
    logic        res_valid;
    logic [15:0] res_i, res_q;

    always #10 clk = ~clk;

    banked_pfir i_banked_pfir (.*);

    int n_vec = 0;
    int n_bad = 0;

    // reference state
    int hist_i [32];
    int hist_q [32];
    int offl [4][32];
    int act [32];
    int m_mi = 0, m_mq = 0, m_gpio_sel = 0, m_breg = 0, m_gpio = 0;
    int m_sh_i = 0, m_sh_q = 0, m_fn_i = 63, m_fn_q = 63;

    task automatic check(string req, int actual, int expected);
        n_vec++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int s16(logic [15:0] v);
        return int'($signed(v));
    endfunction

    function automatic int model(int mode, bit isq, int sh, int fn);
        int cnt, base, s;
        longint acc, y, z;
        cnt = (mode == 7) ? 32 : (mode == 2) ? 16 : (mode == 1) ? 8 : 0;
        if (cnt == 0) return isq ? hist_q[0] : hist_i[0];
        base = (isq && mode != 7) ? 16 : 0;
        acc = 0;
        for (int k = 0; k < cnt; k++)
            acc += longint'(act[base + k]) * longint'(isq ? hist_q[k] : hist_i[k]);
        y = acc >>> 15;
        s = (sh <= 4) ? sh : 0;
        z = ((y <<< s) * longint'(fn + 1)) >>> 6;
        if (z > 32767) z = 32767;
        if (z < -32768) z = -32768;
        return int'(z);
    endfunction

    task automatic route(int mi, int mq, int gsel, int breg);
        @(negedge clk);
        route_we = 1'b1; route_mode_i = 3'(mi); route_mode_q = 3'(mq);
        route_sel_gpio = gsel[0]; route_bank_reg = 2'(breg);
        @(negedge clk);
        route_we = 1'b0;
        m_mi = mi; m_mq = mq; m_gpio_sel = gsel; m_breg = breg;
    endtask

    task automatic gains(int shi, int shq, int fi, int fq);
        @(negedge clk);
        gain_we = 1'b1; gain_shift_i = 3'(shi); gain_shift_q = 3'(shq);
        gain_fine_i = 6'(fi); gain_fine_q = 6'(fq);
        @(negedge clk);
        gain_we = 1'b0;
        m_sh_i = shi; m_sh_q = shq; m_fn_i = fi; m_fn_q = fq;
    endtask

    task automatic load(int mask, int addr, int val);
        @(negedge clk);
        coef_wr = 1'b1; coef_bank_mask = 4'(mask); coef_addr = 5'(addr); coef_data = 16'(val);
        @(negedge clk);
        coef_wr = 1'b0;
        for (int b = 0; b < 4; b++)
            if (mask[b]) offl[b][addr] = s16(16'(val));
    endtask

    task automatic xfer();
        int bsel;
        @(negedge clk);
        coef_xfer = 1'b1;
        @(negedge clk);
        coef_xfer = 1'b0;
        bsel = m_gpio_sel ? m_gpio : m_breg;
        for (int k = 0; k < 32; k++) act[k] = offl[bsel][k];
    endtask

    // drive one sample, check latency and both results
    task automatic send(string req, int vi, int vq);
        int ei, eq;
        @(negedge clk);
        smp_valid = 1'b1; smp_i = 16'(vi); smp_q = 16'(vq);
        for (int k = 31; k > 0; k--) begin
            hist_i[k] = hist_i[k-1];
            hist_q[k] = hist_q[k-1];
        end
        hist_i[0] = s16(16'(vi));
        hist_q[0] = s16(16'(vq));
        ei = model(m_mi, 1'b0, m_sh_i, m_fn_i);
        eq = model(m_mq, 1'b1, m_sh_q, m_fn_q);
        @(negedge clk);
        smp_valid = 1'b0;
        check("R2 early valid", int'(res_valid), 0);
        @(negedge clk);
        check("R2 valid", int'(res_valid), 1);
        check({req, " I"}, s16(res_i), ei);
        check({req, " Q"}, s16(res_q), eq);
        @(negedge clk);
        check("R2 single pulse", int'(res_valid), 0);
    endtask

    task automatic fill_bank(int mask, int seed);
        for (int k = 0; k < 32; k++)
            load(mask, k, ((k * 53 + seed) % 1700) - 850);
    endtask

    task automatic t_reset_state();
        check("R1 res_valid", int'(res_valid), 0);
        check("R1 res_i", s16(res_i), 0);
        check("R1 res_q", s16(res_q), 0);
        send("R1 default bypass", 1234, -4321);
    endtask

    task automatic t_offline_isolated();
        fill_bank(4'h1, 11);
        route(7, 7, 0, 0);
        send("R7 offline only", 3000, -2500);
        check("R7 active still zero I", s16(res_i), 0);
    endtask

    task automatic t_full32();
        xfer();
        send("R3 full", 2000, 1500);
        send("R3 full", -1000, 2900);
        send("R3 full", 2500, -3000);
        for (int n = 0; n < 30; n++) send("R3 full", (n * 311) % 5000 - 2500, 1700 - n * 97);
    endtask

    task automatic t_split16();
        route(2, 2, 0, 0);
        for (int n = 0; n < 18; n++) send("R4 half", n * 150 - 1200, 900 - n * 120);
    endtask

    task automatic t_split8();
        route(1, 1, 0, 0);
        for (int n = 0; n < 10; n++) send("R5 quarter", 2000 - n * 400, n * 333 - 1500);
        route(7, 1, 0, 0);
        send("R5 mixed", 777, -888);
    endtask

    task automatic t_bypass_codes();
        int codes [5] = '{0, 3, 4, 5, 6};
        foreach (codes[c]) begin
            route(codes[c], codes[c], 0, 0);
            send("R6 pass", 500 + c * 1000, -700 - c * 900);
        end
    endtask

    task automatic t_gpio_select();
        fill_bank(4'h4, 401);
        bank_gpio = 2'd2; m_gpio = 2;
        route(7, 7, 1, 0);
        xfer();
        check("R8 gpio bank slot0", s16(16'(act[0])), offl[2][0]);
        for (int n = 0; n < 4; n++) send("R8 gpio bank", 1100 - n * 600, n * 700);
        route(7, 7, 0, 0);
        xfer();
        send("R8 reg bank", 1800, -1800);
    endtask

    task automatic t_mask_all();
        load(4'hF, 5, 4096);
        route(7, 7, 0, 3);
        xfer();
        send("R7 all-bank write b3", 2222, -1111);
        route(7, 7, 0, 1);
        xfer();
        send("R7 all-bank write b1", -3333, 1212);
    endtask

    task automatic t_gain();
        route(7, 7, 0, 0);
        xfer();
        for (int s = 0; s < 8; s++) begin
            gains(s, 7 - s, 63, 63);
            send("R9 shift", 2100, -1900);
        end
        gains(0, 2, 0, 31);
        send("R10 fine", 2600, 2600);
        gains(1, 0, 47, 5);
        send("R10 fine", -2400, 1300);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 32; k++) load(4'h8, k, 16'h7FFF);
        route(7, 7, 0, 3);
        xfer();
        gains(4, 4, 63, 63);
        for (int n = 0; n < 4; n++) send("R11 sat", 30000, -30000);
        check("R11 high clamp", s16(res_i), 32767);
        check("R11 low clamp", s16(res_q), -32768);
    endtask

    initial begin
        foreach (hist_i[k]) begin hist_i[k] = 0; hist_q[k] = 0; act[k] = 0; end
        foreach (offl[b, k]) offl[b][k] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_offline_isolated();
        t_full32();
        t_split16();
        t_split8();
        t_bypass_codes();
        t_gpio_select();
        t_mask_all();
        t_gain();
        t_saturate();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule